// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Selectable Polarity

This block produces six independent pulse-width modulated outputs from a shared clock-source strobe (`tick`). Software writes each channel's period, duty count, enable and polarity through a small synchronous register port. Each channel runs its own up-counter, which advances once per `tick`. The output starts every period at the level chosen by the polarity bit, and it switches to the other level once the counter reaches the duty count.

Enabling a channel does not start it at once. The waveform begins on the next `tick` after the enable bit is set, so every started channel begins at the start of a full period. Channels 0 and 1 can be chained into a single 16-bit channel. In that mode output 1 carries the wide waveform and output 0 is held low. Polarity writes act at once. Period and duty writes take effect only at a period boundary.

Top module: `mpwm_top`

## Requirements
- R1: After reset every register reads zero and every output is low. The register map is: enable at address 0, polarity at address 1, control at address 2 (bit 0 = chain channels 0/1), period of channel i at address 8+i, duty of channel i at address 16+i. In the enable and polarity registers, bit i belongs to channel i, and bits 7:6 always read zero.
- R2: With polarity 1, an enabled channel of period P and duty D (0 < D < P) is high for D ticks and then low for P-D ticks, and this repeats every P ticks.
- R3: With polarity 0, the waveform is the inverse of R2: low for D ticks, then high for P-D ticks.
- R4: Duty 0 gives a constant inactive level (low for polarity 1, high for polarity 0). A duty at or above the period gives a constant active level.
- R5: After an enable bit is set, the output stays low until the first `tick`. On that tick the counter starts at zero and the output goes to the active level.
- R6: A disabled channel drives its output low and holds its counter at zero. Clearing the enable bit forces the output low within two clock edges of the write.
- R7: A polarity write changes the output level on the first cycle after the write.
- R8: Period and duty writes to a running channel take effect only when its counter wraps.
- R9: With the chain bit set, output 0 stays low regardless of channel 0's enable. Output 1 carries a 16-bit waveform whose period and duty take channel 0 as the high byte and channel 1 as the low byte, and which uses channel 1's enable and polarity.
- R10: A running counter changes only on a cycle with `tick` high, and it stays below its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-source strobe; each high cycle advances the running counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| pwm_out | output | 6 | Channel outputs, bit i = channel i |

## Verification
A counter that is off by one shows up at once as a high or low time one tick too long. The sweep sees that within the first period after the channel starts. A duty or period latched at the wrong moment, or a start that ignores `tick`, moves the first edge of the output. The bench checks that edge on the very cycle it is due. A chain mux with its bytes swapped gives a 16-bit period hundreds of ticks off, and a broken output-0 gate shows a high level on pin 0 during the chained run.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_CH = 6;
  localparam int unsigned WIDE_W = 2 * BYTE_W;

  localparam int unsigned A_ENA  = 0;
  localparam int unsigned A_POL  = 1;
  localparam int unsigned A_CTL  = 2;
  localparam int unsigned A_PER  = 8;
  localparam int unsigned A_DUTY = 16;

  // Counter is still inside the active part of the period.
  function automatic logic in_active(input logic [WIDE_W-1:0] cnt,
                                     input logic [WIDE_W-1:0] duty);
    return cnt < duty;
  endfunction

  // Counter holds the last count of the period (period 0 counts as 1).
  function automatic logic at_last(input logic [WIDE_W-1:0] cnt,
                                   input logic [WIDE_W-1:0] per);
    return ({1'b0, cnt} + (WIDE_W+1)'(1)) >= {1'b0, per};
  endfunction
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = BYTE_W,
  parameter int unsigned AW  = REG_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [NCH-1:0]          ena_o,
  output logic [NCH-1:0]          pol_o,
  output logic                    chain_o,
  output logic [NCH-1:0][DW-1:0]  per_o,
  output logic [NCH-1:0][DW-1:0]  duty_o
);
  logic [NCH-1:0]         ena_q, pol_q;
  logic                   chain_q;
  logic [NCH-1:0][DW-1:0] per_q, duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q   <= '0;
      pol_q   <= '0;
      chain_q <= 1'b0;
      per_q   <= '0;
      duty_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_ENA)) ena_q <= wr_data[NCH-1:0];
      if (wr_addr == AW'(A_POL)) pol_q <= wr_data[NCH-1:0];
      if (wr_addr == AW'(A_CTL)) chain_q <= wr_data[0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == AW'(A_PER + i))  per_q[i]  <= wr_data;
        if (wr_addr == AW'(A_DUTY + i)) duty_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_ENA)) rd_data = DW'(ena_q);
    if (rd_addr == AW'(A_POL)) rd_data = DW'(pol_q);
    if (rd_addr == AW'(A_CTL)) rd_data = DW'(chain_q);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(A_PER + i))  rd_data = per_q[i];
      if (rd_addr == AW'(A_DUTY + i)) rd_data = duty_q[i];
    end
  end

  assign ena_o   = ena_q;
  assign pol_o   = pol_q;
  assign chain_o = chain_q;
  assign per_o   = per_q;
  assign duty_o  = duty_q;
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
  import mpwm_pkg::*;
#(
  parameter int unsigned CW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          pol,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] duty,
  output logic          wave,
  output logic          live,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_now,
  output logic          start_evt,
  output logic          wrap_evt
);
  logic          live_q;
  logic [CW-1:0] cnt_q, per_q, duty_q;
  logic          last, act;

  assign last      = at_last(WIDE_W'(cnt_q), WIDE_W'(per_q));
  assign act       = in_active(WIDE_W'(cnt_q), WIDE_W'(duty_q));
  assign start_evt = en & ~live_q & tick;
  assign wrap_evt  = en & live_q & tick & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (!en) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_evt || wrap_evt) begin
      live_q <= 1'b1;
      cnt_q  <= '0;
      per_q  <= per;
      duty_q <= duty;
    end else if (live_q && tick) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign wave    = live_q & (pol ? act : ~act);
  assign live    = live_q;
  assign cnt     = cnt_q;
  assign per_now = per_q;
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
  import mpwm_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = BYTE_W,
  parameter int unsigned AW  = REG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out
);
  localparam int unsigned XW = 2 * DW;

  logic [NCH-1:0]          ena_w, pol_w, live_w, start_w, wrap_w;
  logic                    chain_w;
  logic [NCH-1:0][DW-1:0]  per_w, duty_w;
  logic [NCH-1:0][XW-1:0]  cnt_w, pnow_w;

  mpwm_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ena_o(ena_w), .pol_o(pol_w), .chain_o(chain_w),
    .per_o(per_w), .duty_o(duty_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 1) begin : g_wide
      logic          wave_x;
      logic [XW-1:0] per_x, duty_x, cnt_x, pnow_x;
      assign per_x  = chain_w ? {per_w[0], per_w[1]}   : XW'(per_w[1]);
      assign duty_x = chain_w ? {duty_w[0], duty_w[1]} : XW'(duty_w[1]);
      mpwm_chan #(.CW(XW)) u_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ena_w[i]), .pol(pol_w[i]),
        .per(per_x), .duty(duty_x), .wave(wave_x), .live(live_w[i]),
        .cnt(cnt_x), .per_now(pnow_x), .start_evt(start_w[i]),
        .wrap_evt(wrap_w[i])
      );
      assign cnt_w[i]   = cnt_x;
      assign pnow_w[i]  = pnow_x;
      assign pwm_out[i] = wave_x;
    end else begin : g_narrow
      logic          wave_n, en_n;
      logic [DW-1:0] cnt_n, pnow_n;
      assign en_n = (i == 0) ? (ena_w[i] & ~chain_w) : ena_w[i];
      mpwm_chan #(.CW(DW)) u_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_n), .pol(pol_w[i]),
        .per(per_w[i]), .duty(duty_w[i]), .wave(wave_n), .live(live_w[i]),
        .cnt(cnt_n), .per_now(pnow_n), .start_evt(start_w[i]),
        .wrap_evt(wrap_w[i])
      );
      assign cnt_w[i]   = XW'(cnt_n);
      assign pnow_w[i]  = XW'(pnow_n);
      assign pwm_out[i] = wave_n & ~(chain_w & (i == 0));
    end
  end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk
  import mpwm_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = BYTE_W,
  parameter int unsigned AW  = REG_AW
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [AW-1:0]             rd_addr,
  input logic [DW-1:0]             rd_data,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            ena_w,
  input logic                      chain_w,
  input logic [NCH-1:0]            live_w,
  input logic [NCH-1:0]            start_w,
  input logic [NCH-1:0]            wrap_w,
  input logic [NCH-1:0][2*DW-1:0]  cnt_w,
  input logic [NCH-1:0][2*DW-1:0]  pnow_w
);
  // R9
  chain_pin0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_w |-> !pwm_out[0]);

  if (NCH < DW) begin : g_rd
    // R1
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(A_ENA) || rd_addr == AW'(A_POL)) |-> rd_data[DW-1:NCH] == '0);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R6
    off_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena_w[i] && !$past(ena_w[i])) |-> !pwm_out[i]);
    // R6
    off_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !live_w[i] |-> cnt_w[i] == '0);
    // R5
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(live_w[i]) |-> ($past(tick) && $past(ena_w[i])));
    // R5
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_w[i] |=> (live_w[i] && cnt_w[i] == '0));
    // R8
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_w[i] |=> cnt_w[i] == '0);
    // R10
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_w[i] && pnow_w[i] != '0) |-> cnt_w[i] < pnow_w[i]);
    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_w[i] && $past(live_w[i]) && !$past(tick)) |-> $stable(cnt_w[i]));
  end
endmodule

bind mpwm_top mpwm_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_addr(rd_addr), .rd_data(rd_data),
  .pwm_out(pwm_out), .ena_w(ena_w), .chain_w(chain_w), .live_w(live_w),
  .start_w(start_w), .wrap_w(wrap_w), .cnt_w(cnt_w), .pnow_w(pnow_w)
);

// File: tb/mpwm_top_test.sv
module mpwm_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] pwm_out;
  int checks = 0;
  int fails = 0;

  mpwm_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write lands.
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic lvl(input int k, input int duty, input logic pol);
    return pol ? (k < duty) : !(k < duty);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwm_out, 0, "R1 outputs after reset");
    rd_addr = 0; #0.1 chk(rd_data, 0, "R1 enable reg reset");
    rd_addr = 1; #0.1 chk(rd_data, 0, "R1 polarity reg reset");
    rd_addr = 2; #0.1 chk(rd_data, 0, "R1 control reg reset");
    wr(1, 8'hFF);
    rd_addr = 1; #0.1 chk(rd_data, 8'h3F, "R1 polarity upper bits");
    wr(0, 8'hFF);
    rd_addr = 0; #0.1 chk(rd_data, 8'h3F, "R1 enable upper bits");
    wr(0, 0);
    wr(1, 0);
    @(negedge clk);

    // R2 R3 R4 sweep on channel 2
    for (int pol = 0; pol < 2; pol++)
      for (int per = 1; per <= 6; per++)
        for (int duty = 0; duty <= 7; duty++) begin
          tick = 1'b0;
          wr(1, pol ? 8'h04 : 8'h00);
          wr(8 + 2, 8'(per));
          wr(16 + 2, 8'(duty));
          wr(0, 8'h04);
          chk(pwm_out[2], 0, "R5 no output before tick");
          tick = 1'b1;
          @(negedge clk);
          for (int k = 0; k < 2 * per; k++) begin
            chk(pwm_out[2], lvl(k % per, duty, pol[0]),
                pol ? "R2/R4 polarity 1 waveform" : "R3/R4 polarity 0 waveform");
            @(negedge clk);
          end
          tick = 1'b0;
          wr(0, 0);
          @(negedge clk);
          chk(pwm_out[2], 0, "R6 disabled output low");
        end

    // R8 duty reload at wrap, channel 3, period 4
    wr(1, 8'h08); wr(8 + 3, 4); wr(16 + 3, 1); wr(0, 8'h08);
    tick = 1'b1;
    @(negedge clk);
    chk(pwm_out[3], 1, "R8 k0 high");
    @(negedge clk);
    chk(pwm_out[3], 0, "R8 k1 low");
    wr(16 + 3, 3);
    chk(pwm_out[3], 0, "R8 k2 keeps old duty");
    @(negedge clk); chk(pwm_out[3], 0, "R8 k3 keeps old duty");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pwm_out[3], k < 3, "R8 new duty after wrap");
    end
    tick = 1'b0;
    wr(0, 0);
    @(negedge clk);

    // R5 deferred enable and R7 polarity, channel 4 constant active
    wr(1, 8'h10); wr(8 + 4, 3); wr(16 + 4, 3); wr(0, 8'h10);
    for (int k = 0; k < 4; k++) begin
      chk(pwm_out[4], 0, "R5 waits for tick");
      @(negedge clk);
    end
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(pwm_out[4], 1, "R5 active after first tick");
    @(negedge clk);
    chk(pwm_out[4], 1, "R10 holds without tick");
    wr(1, 8'h00);
    chk(pwm_out[4], 0, "R7 polarity 0 applied at once");
    wr(1, 8'h10);
    chk(pwm_out[4], 1, "R7 polarity 1 applied at once");
    wr(0, 0);
    @(negedge clk);
    chk(pwm_out[4], 0, "R6 low after disable");

    // R9 chained 16-bit channel: period 0x0102, duty 0x0005
    wr(2, 1); wr(8, 8'h01); wr(9, 8'h02); wr(16, 8'h00); wr(17, 8'h05);
    wr(1, 8'h03); wr(0, 8'h03);
    rd_addr = 2; #0.1 chk(rd_data, 1, "R1 control readback");
    tick = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2 * 258; k++) begin
      chk(pwm_out[1], (k % 258) < 5, "R9 wide waveform");
      chk(pwm_out[0], 0, "R9 pin 0 held low");
      @(negedge clk);
    end
    tick = 1'b0;
    wr(0, 0); wr(2, 0);
    @(negedge clk);

    // R9 unchained: channel 1 back to 8-bit, period 2 duty 1
    wr(9, 2); wr(17, 1); wr(1, 8'h02); wr(0, 8'h02);
    tick = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(pwm_out[1], (k % 2) < 1, "R9 channel 1 narrow after unchain");
      @(negedge clk);
    end
    tick = 1'b0;
    wr(0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule